// File: doc/BRIEF.md
# Cache miss tracking entry

This block is one miss-tracking slot of a snooping cache. Once a miss is allocated it holds the block address, an order tag and two short target FIFOs. The primary FIFO holds the requests that the outstanding bus request will satisfy. The deferred FIFO holds the requests that have to wait for a second request after the fill. Each target carries a command code, a needs-exclusive bit, a cpu-side bit and an order tag. Each FIFO also keeps an exclusive flag and an upgrade-present flag.

Surrounding cache logic drives one operation per cycle: allocate, add a target, issue, snoop, fill, pop the primary head, promote the deferred FIFO, or release. Snoops and fills get their answers in the same cycle on combinational outputs: handled, shared, inhibit and supply-exclusive for a snoop, and a shared indication for a fill. Snoops that arrive while the miss is outstanding are recorded as memory-side targets or leave behind pending-invalidate and pending-shared state. Queued upgrades are rewritten to read-exclusive when an invalidating snoop wins the race.

Top module: `miss_entry`

## Requirements
- R1: After reset the entry is not busy, both FIFO counts are 0, and in-service, pending-invalidate, pending-shared and the error flag are all clear.
- R2: An allocate while not busy stores the address and order tag. The primary FIFO then holds exactly that one target, with cpu-side = 1. The deferred FIFO is empty and in-service, pending-invalidate and pending-shared are clear.
- R3: An added target goes to the deferred FIFO only when the entry is in service and at least one of these holds: the deferred FIFO is non-empty, an invalidate is pending, or the primary FIFO is not exclusive while the target needs exclusive. Otherwise it goes to the primary FIFO. Command codes are 0 = read, 1 = read-exclusive, 2 = upgrade.
- R4: At most one operation is presented per cycle. `full` is high when the two FIFO counts sum to DEPTH, and an add presented while full changes nothing.
- R5: Issuing a forwarded entry pulses `issue_release`, empties the primary FIFO and leaves in-service clear. Issuing any other entry sets in-service.
- R6: A snoop is unhandled and leaves the entry unchanged when the entry is not in service, or when the snoop is express while `ds_pend` is high. The one exception is an exclusive snoop under these conditions, which rewrites every upgrade (2) to read-exclusive (1) in both FIFOs.
- R7: Other snoops are handled, and the steps apply in this order. An exclusive snoop first rewrites the deferred upgrades. If an invalidate is pending, nothing more happens. Otherwise, if the primary FIFO or the snoop is exclusive, the snoop is appended to the primary FIFO as cpu-side = 0 with cmd 1 if exclusive and 0 if not. Otherwise pending-shared is set and `snoop_shared` is asserted.
- R8: A recorded snoop asserts inhibit and supply-exclusive exactly when the primary FIFO is exclusive. An exclusive recorded snoop sets pending-invalidate.
- R9: A fill asserts `fill_shared_out` when the response is shared or pending-shared is set. If the result is not shared, no invalidate is pending and the deferred FIFO is exclusive, the deferred targets are appended in order to the primary FIFO and the deferred FIFO is emptied.
- R10: Promote acts only when the primary FIFO is empty and the deferred FIFO is not. It moves the deferred targets into the primary FIFO, clears pending-invalidate, pending-shared and in-service, and takes the entry order tag from the new head.
- R11: Pop removes the primary head, and targets leave in the order they entered.
- R12: Release frees the entry when both FIFOs are empty. A release at any other time leaves the entry busy and sets a sticky error flag that only reset clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_valid | input | 1 | Allocate request |
| alloc_addr | input | ADDR_W | Block address |
| alloc_cmd | input | 2 | Command of first target |
| alloc_excl | input | 1 | First target needs exclusive |
| alloc_fwd | input | 1 | Plain forward, no response expected |
| alloc_order | input | ORD_W | Order tag of first target |
| add_valid | input | 1 | Add a cpu-side target |
| add_cmd | input | 2 | Command of added target |
| add_excl | input | 1 | Added target needs exclusive |
| add_order | input | ORD_W | Order tag of added target |
| issue_valid | input | 1 | Request sent downstream |
| issue_release | output | 1 | Forwarded entry may be freed now |
| ds_pend | input | 1 | Own request still buffered below |
| snoop_valid | input | 1 | Snooped bus request |
| snoop_excl | input | 1 | Snoop invalidates |
| snoop_express | input | 1 | Snoop is express |
| snoop_order | input | ORD_W | Order tag of snoop |
| snoop_handled | output | 1 | Snoop handled by this entry |
| snoop_shared | output | 1 | Assert shared on snoop |
| snoop_inhibit | output | 1 | Inhibit memory response |
| snoop_supply_excl | output | 1 | This entry supplies exclusive copy |
| fill_valid | input | 1 | Fill response arrives |
| fill_shared_in | input | 1 | Response marked shared |
| fill_shared_out | output | 1 | Response to be treated as shared |
| pop_valid | input | 1 | Remove primary head |
| promote_valid | input | 1 | Promote deferred FIFO |
| release_valid | input | 1 | Free the entry |
| busy | output | 1 | Entry allocated |
| in_service | output | 1 | Request outstanding |
| pend_inv | output | 1 | Invalidate pending |
| pend_shared | output | 1 | Shared pending |
| full | output | 1 | FIFOs hold DEPTH targets |
| err | output | 1 | Sticky illegal-release flag |
| entry_addr | output | ADDR_W | Stored address |
| entry_order | output | ORD_W | Entry order tag |
| prim_count | output | CW | Primary FIFO count |
| def_count | output | CW | Deferred FIFO count |
| head_valid | output | 1 | Primary FIFO non-empty |
| head_cmd | output | 2 | Head command |
| head_excl | output | 1 | Head needs exclusive |
| head_cpu | output | 1 | Head is cpu-side |
| head_order | output | ORD_W | Head order tag |

## Verification
The hardest states to reach are those where a deferred FIFO already holds an upgrade at the moment an invalidating snoop arrives, and where a fill lands with pending-invalidate or pending-shared already set. The bench reaches each of them with a short scripted sequence: allocate, issue, a conflicting add, and then the snoop. It also sweeps all 32 combinations of primary exclusivity, snoop exclusivity, express, downstream-pending and issued state, and computes the snoop answers arithmetically. Rewritten commands in the deferred FIFO are read back through promote and the head outputs.

// File: rtl/miss_entry.sv
module miss_entry #(
  parameter int ADDR_W = 32,
  parameter int ORD_W  = 8,
  parameter int DEPTH  = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [1:0]        alloc_cmd,
  input  logic              alloc_excl,
  input  logic              alloc_fwd,
  input  logic [ORD_W-1:0]  alloc_order,
  input  logic              add_valid,
  input  logic [1:0]        add_cmd,
  input  logic              add_excl,
  input  logic [ORD_W-1:0]  add_order,
  input  logic              issue_valid,
  output logic              issue_release,
  input  logic              ds_pend,
  input  logic              snoop_valid,
  input  logic              snoop_excl,
  input  logic              snoop_express,
  input  logic [ORD_W-1:0]  snoop_order,
  output logic              snoop_handled,
  output logic              snoop_shared,
  output logic              snoop_inhibit,
  output logic              snoop_supply_excl,
  input  logic              fill_valid,
  input  logic              fill_shared_in,
  output logic              fill_shared_out,
  input  logic              pop_valid,
  input  logic              promote_valid,
  input  logic              release_valid,
  output logic              busy,
  output logic              in_service,
  output logic              pend_inv,
  output logic              pend_shared,
  output logic              full,
  output logic              err,
  output logic [ADDR_W-1:0] entry_addr,
  output logic [ORD_W-1:0]  entry_order,
  output logic [CW-1:0]     prim_count,
  output logic [CW-1:0]     def_count,
  output logic              head_valid,
  output logic [1:0]        head_cmd,
  output logic              head_excl,
  output logic              head_cpu,
  output logic [ORD_W-1:0]  head_order
);

  typedef struct packed {
    logic [1:0]       cmd;
    logic             ex;
    logic             cpu;
    logic [ORD_W-1:0] ord;
  } tgt_t;

  localparam logic [1:0]    C_RD  = 2'd0;
  localparam logic [1:0]    C_RDX = 2'd1;
  localparam logic [1:0]    C_UPG = 2'd2;
  localparam logic [CW-1:0] ONE   = CW'(1);

  function automatic tgt_t fix_upg(tgt_t t);
    tgt_t r = t;
    if (r.cmd == C_UPG) r.cmd = C_RDX;
    return r;
  endfunction

  tgt_t pq [DEPTH];
  tgt_t dq [DEPTH];
  tgt_t pq_n [DEPTH];
  tgt_t dq_n [DEPTH];
  tgt_t nt;

  logic [CW-1:0] pn, dn, pn_n, dn_n;
  logic [CW:0]   tot;
  logic p_nx, p_up, d_nx, d_up, p_nx_n, p_up_n, d_nx_n, d_up_n;
  logic vld, insvc, fwd, pinv, psh, err_q;
  logic vld_n, insvc_n, fwd_n, pinv_n, psh_n, err_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [ORD_W-1:0]  ord_q, ord_n;
  logic to_def, fsh;

  assign tot  = {1'b0, pn} + {1'b0, dn};
  assign full = (tot == (CW+1)'(DEPTH));

  always_comb begin
    pq_n = pq;  dq_n = dq;  pn_n = pn;  dn_n = dn;
    p_nx_n = p_nx;  p_up_n = p_up;  d_nx_n = d_nx;  d_up_n = d_up;
    vld_n = vld;  insvc_n = insvc;  fwd_n = fwd;  pinv_n = pinv;  psh_n = psh;
    err_n = err_q;  addr_n = addr_q;  ord_n = ord_q;
    nt = '0;  to_def = 1'b0;  fsh = 1'b0;
    issue_release = 1'b0;  snoop_handled = 1'b0;  snoop_shared = 1'b0;
    snoop_inhibit = 1'b0;  snoop_supply_excl = 1'b0;  fill_shared_out = 1'b0;
    if (!vld) begin
      if (alloc_valid) begin
        vld_n = 1'b1;  addr_n = alloc_addr;  ord_n = alloc_order;  fwd_n = alloc_fwd;
        insvc_n = 1'b0;  pinv_n = 1'b0;  psh_n = 1'b0;
        nt.cmd = alloc_cmd;  nt.ex = alloc_excl;  nt.cpu = 1'b1;  nt.ord = alloc_order;
        pq_n[0] = nt;  pn_n = ONE;  dn_n = '0;
        p_nx_n = alloc_excl;  p_up_n = (alloc_cmd == C_UPG);
        d_nx_n = 1'b0;  d_up_n = 1'b0;
      end
    end else if (issue_valid) begin
      if (!insvc) begin
        if (fwd) begin
          issue_release = 1'b1;
          pn_n = '0;
        end else begin
          insvc_n = 1'b1;
        end
      end
    end else if (snoop_valid) begin
      if (!insvc || (snoop_express && ds_pend)) begin
        if (snoop_excl) begin
          for (int i = 0; i < DEPTH; i++) begin
            if (p_up && i < int'(pn)) pq_n[i] = fix_upg(pq[i]);
            if (d_up && i < int'(dn)) dq_n[i] = fix_upg(dq[i]);
          end
          p_up_n = 1'b0;
          d_up_n = 1'b0;
        end
      end else begin
        snoop_handled = 1'b1;
        if (snoop_excl) begin
          for (int i = 0; i < DEPTH; i++)
            if (d_up && i < int'(dn)) dq_n[i] = fix_upg(dq[i]);
          d_up_n = 1'b0;
        end
        if (!pinv) begin
          if (p_nx || snoop_excl) begin
            nt.cmd = snoop_excl ? C_RDX : C_RD;
            nt.ex  = snoop_excl;
            nt.cpu = 1'b0;
            nt.ord = snoop_order;
            pq_n[pn[IW-1:0]] = nt;
            pn_n = pn + ONE;
            snoop_inhibit     = p_nx;
            snoop_supply_excl = p_nx;
            if (snoop_excl) pinv_n = 1'b1;
          end else begin
            psh_n = 1'b1;
            snoop_shared = 1'b1;
          end
        end
      end
    end else if (fill_valid) begin
      fsh = fill_shared_in | psh;
      fill_shared_out = fsh;
      if (!fsh && !pinv && d_nx) begin
        for (int i = 0; i < DEPTH; i++)
          if (i >= int'(pn) && i < int'(pn) + int'(dn)) pq_n[i] = dq[i - int'(pn)];
        pn_n = pn + dn;
        dn_n = '0;
        p_nx_n = 1'b1;
        p_up_n = p_up | d_up;
        d_nx_n = 1'b0;
        d_up_n = 1'b0;
      end
    end else if (promote_valid) begin
      if (pn == '0 && dn != '0) begin
        pq_n = dq;
        pn_n = dn;
        dn_n = '0;
        p_nx_n = d_nx;  p_up_n = d_up;
        d_nx_n = 1'b0;  d_up_n = 1'b0;
        pinv_n = 1'b0;  psh_n = 1'b0;  insvc_n = 1'b0;
        ord_n = dq[0].ord;
      end
    end else if (add_valid) begin
      if (!full) begin
        nt.cmd = add_cmd;  nt.ex = add_excl;  nt.cpu = 1'b1;  nt.ord = add_order;
        to_def = insvc && (dn != '0 || pinv || (!p_nx && add_excl));
        if (to_def) begin
          dq_n[dn[IW-1:0]] = nt;
          dn_n = dn + ONE;
          d_nx_n = d_nx | add_excl;
          d_up_n = d_up | (add_cmd == C_UPG);
        end else begin
          pq_n[pn[IW-1:0]] = nt;
          pn_n = pn + ONE;
          p_nx_n = p_nx | add_excl;
          p_up_n = p_up | (add_cmd == C_UPG);
        end
      end
    end else if (pop_valid) begin
      if (pn != '0) begin
        for (int i = 0; i < DEPTH - 1; i++) pq_n[i] = pq[i+1];
        pn_n = pn - ONE;
      end
    end else if (release_valid) begin
      if (pn == '0 && dn == '0) begin
        vld_n = 1'b0;  insvc_n = 1'b0;  pinv_n = 1'b0;  psh_n = 1'b0;
      end else begin
        err_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        pq[i] <= '0;
        dq[i] <= '0;
      end
      pn <= '0;  dn <= '0;
      p_nx <= 1'b0;  p_up <= 1'b0;  d_nx <= 1'b0;  d_up <= 1'b0;
      vld <= 1'b0;  insvc <= 1'b0;  fwd <= 1'b0;  pinv <= 1'b0;  psh <= 1'b0;
      err_q <= 1'b0;  addr_q <= '0;  ord_q <= '0;
    end else begin
      pq <= pq_n;  dq <= dq_n;  pn <= pn_n;  dn <= dn_n;
      p_nx <= p_nx_n;  p_up <= p_up_n;  d_nx <= d_nx_n;  d_up <= d_up_n;
      vld <= vld_n;  insvc <= insvc_n;  fwd <= fwd_n;  pinv <= pinv_n;  psh <= psh_n;
      err_q <= err_n;  addr_q <= addr_n;  ord_q <= ord_n;
    end
  end

  assign busy        = vld;
  assign in_service  = insvc;
  assign pend_inv    = pinv;
  assign pend_shared = psh;
  assign err         = err_q;
  assign entry_addr  = addr_q;
  assign entry_order = ord_q;
  assign prim_count  = pn;
  assign def_count   = dn;
  assign head_valid  = (pn != '0);
  assign head_cmd    = pq[0].cmd;
  assign head_excl   = pq[0].ex;
  assign head_cpu    = pq[0].cpu;
  assign head_order  = pq[0].ord;

  a_r4_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({alloc_valid, add_valid, issue_valid, snoop_valid, fill_valid,
                pop_valid, promote_valid, release_valid}) <= 1);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    tot <= (CW+1)'(DEPTH));
  a_r4_snoop_room: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && snoop_valid) |-> !full);
  a_r3_defer_needs_service: assert property (@(posedge clk) disable iff (!rst_n)
    (dn != '0) |-> insvc);
  a_r8_inv_needs_service: assert property (@(posedge clk) disable iff (!rst_n)
    pinv |-> insvc);
  a_r8_inhibit_records: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && snoop_valid && snoop_inhibit) |=> (pn == $past(pn) + ONE));
  a_r7_shared_remembered: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && snoop_valid && snoop_shared) |=> psh);
  a_r5_fwd_empties: assert property (@(posedge clk) disable iff (!rst_n)
    issue_release |=> (pn == '0 && !insvc));
  a_r10_promote_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && promote_valid && pn == '0 && dn != '0) |=> (dn == '0 && !pinv && !psh && !insvc));
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: tb/test_miss_entry.sv
`timescale 1ns/1ps
module test_miss_entry;
  localparam int ADDR_W = 32;
  localparam int ORD_W  = 8;
  localparam int DEPTH  = 4;
  localparam int CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, alloc_excl = 0, alloc_fwd = 0;
  logic [ADDR_W-1:0] alloc_addr = '0;
  logic [1:0] alloc_cmd = '0, add_cmd = '0;
  logic [ORD_W-1:0] alloc_order = '0, add_order = '0, snoop_order = '0;
  logic add_valid = 0, add_excl = 0, issue_valid = 0, ds_pend = 0;
  logic snoop_valid = 0, snoop_excl = 0, snoop_express = 0;
  logic fill_valid = 0, fill_shared_in = 0, pop_valid = 0, promote_valid = 0, release_valid = 0;
  logic issue_release, snoop_handled, snoop_shared, snoop_inhibit, snoop_supply_excl, fill_shared_out;
  logic busy, in_service, pend_inv, pend_shared, full, err;
  logic [ADDR_W-1:0] entry_addr;
  logic [ORD_W-1:0] entry_order, head_order;
  logic [CW-1:0] prim_count, def_count;
  logic head_valid, head_excl, head_cpu;
  logic [1:0] head_cmd;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic c_rel, c_h, c_s, c_i, c_x, c_fso;

  always #4 clk = ~clk;

  miss_entry #(.ADDR_W(ADDR_W), .ORD_W(ORD_W), .DEPTH(DEPTH)) i_miss_entry (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_cmd(alloc_cmd),
    .alloc_excl(alloc_excl), .alloc_fwd(alloc_fwd), .alloc_order(alloc_order),
    .add_valid(add_valid), .add_cmd(add_cmd), .add_excl(add_excl), .add_order(add_order),
    .issue_valid(issue_valid), .issue_release(issue_release), .ds_pend(ds_pend),
    .snoop_valid(snoop_valid), .snoop_excl(snoop_excl), .snoop_express(snoop_express),
    .snoop_order(snoop_order), .snoop_handled(snoop_handled), .snoop_shared(snoop_shared),
    .snoop_inhibit(snoop_inhibit), .snoop_supply_excl(snoop_supply_excl),
    .fill_valid(fill_valid), .fill_shared_in(fill_shared_in), .fill_shared_out(fill_shared_out),
    .pop_valid(pop_valid), .promote_valid(promote_valid), .release_valid(release_valid),
    .busy(busy), .in_service(in_service), .pend_inv(pend_inv), .pend_shared(pend_shared),
    .full(full), .err(err), .entry_addr(entry_addr), .entry_order(entry_order),
    .prim_count(prim_count), .def_count(def_count), .head_valid(head_valid),
    .head_cmd(head_cmd), .head_excl(head_excl), .head_cpu(head_cpu), .head_order(head_order)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_alloc(input logic [31:0] a, input logic [1:0] c, input logic x,
                          input logic f, input logic [7:0] o);
    alloc_valid = 1; alloc_addr = a; alloc_cmd = c; alloc_excl = x; alloc_fwd = f; alloc_order = o;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic do_add(input logic [1:0] c, input logic x, input logic [7:0] o);
    add_valid = 1; add_cmd = c; add_excl = x; add_order = o;
    @(negedge clk);
    add_valid = 0;
  endtask

  task automatic do_issue();
    issue_valid = 1; #1; c_rel = issue_release;
    @(negedge clk);
    issue_valid = 0;
  endtask

  task automatic do_snoop(input logic x, input logic xp, input logic [7:0] o);
    snoop_valid = 1; snoop_excl = x; snoop_express = xp; snoop_order = o;
    #1; c_h = snoop_handled; c_s = snoop_shared; c_i = snoop_inhibit; c_x = snoop_supply_excl;
    @(negedge clk);
    snoop_valid = 0; snoop_excl = 0; snoop_express = 0;
  endtask

  task automatic do_fill(input logic sh);
    fill_valid = 1; fill_shared_in = sh; #1; c_fso = fill_shared_out;
    @(negedge clk);
    fill_valid = 0; fill_shared_in = 0;
  endtask

  task automatic do_pop();
    pop_valid = 1; @(negedge clk); pop_valid = 0;
  endtask

  task automatic do_promote();
    promote_valid = 1; @(negedge clk); promote_valid = 0;
  endtask

  task automatic do_release();
    release_valid = 1; @(negedge clk); release_valid = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 prim_count", prim_count, 0);
    chk("R1 def_count", def_count, 0);
    chk("R1 flags", {in_service, pend_inv, pend_shared, err}, 0);

    // R2 allocate
    do_alloc(32'h1234_5640, 2'd2, 1, 0, 8'd33);
    chk("R2 busy", busy, 1);
    chk("R2 addr", entry_addr, 32'h1234_5640);
    chk("R2 order", entry_order, 33);
    chk("R2 prim_count", prim_count, 1);
    chk("R2 def_count", def_count, 0);
    chk("R2 head", {head_cmd, head_excl, head_cpu, head_order}, {2'd2, 1'b1, 1'b1, 8'd33});
    chk("R2 flags", {in_service, pend_inv, pend_shared}, 0);

    // R3 routing sweep over primary and target exclusivity, in service
    for (int k = 0; k < 4; k++) begin
      logic pe, ae, d;
      pe = k[0]; ae = k[1]; d = !pe && ae;
      do_reset();
      do_alloc(32'h100, pe ? 2'd1 : 2'd0, pe, 0, 8'd1);
      do_issue();
      do_add(ae ? 2'd1 : 2'd0, ae, 8'd2);
      chk("R3 sweep def_count", def_count, d);
      chk("R3 sweep prim_count", prim_count, d ? 1 : 2);
    end
    // R3 not in service: exclusive add stays primary
    do_reset();
    do_alloc(32'h100, 2'd0, 0, 0, 8'd1);
    do_add(2'd1, 1, 8'd2);
    chk("R3 not issued prim", prim_count, 2);
    // R3 pending invalidate and non-empty deferred force deferral
    do_reset();
    do_alloc(32'h100, 2'd0, 0, 0, 8'd1);
    do_issue();
    do_snoop(1, 0, 8'd9);
    chk("R8 pinv set", pend_inv, 1);
    chk("R8 no inhibit on shared primary", {c_i, c_x}, 0);
    do_snoop(0, 0, 8'd10);
    chk("R7 pinv handled", c_h, 1);
    chk("R7 pinv no shared", c_s, 0);
    chk("R7 pinv no append", prim_count, 2);
    do_add(2'd0, 0, 8'd3);
    chk("R3 pinv defers", def_count, 1);
    do_add(2'd1, 1, 8'd4);
    chk("R3 deferred nonempty defers", def_count, 2);
    chk("R4 full", full, 1);
    do_fill(0);
    chk("R9 pinv blocks splice", def_count, 2);
    chk("R9 fso", c_fso, 0);
    // R10 promote ignored while primary non-empty
    do_promote();
    chk("R10 ignored def", def_count, 2);
    chk("R10 ignored prim", prim_count, 2);
    do_pop();
    do_pop();
    do_promote();
    chk("R10 prim", prim_count, 2);
    chk("R10 def", def_count, 0);
    chk("R10 flags", {pend_inv, pend_shared, in_service}, 0);
    chk("R10 order", entry_order, 3);
    chk("R11 head after promote", head_order, 3);

    // R4 add while full ignored; R11 FIFO order
    do_reset();
    do_alloc(32'h200, 2'd0, 0, 0, 8'd5);
    do_add(2'd0, 0, 8'd6);
    do_add(2'd0, 0, 8'd7);
    do_add(2'd0, 0, 8'd8);
    chk("R4 full flag", full, 1);
    do_add(2'd0, 0, 8'd99);
    chk("R4 ignored count", prim_count, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R11 pop order", head_order, 5 + k);
      do_pop();
    end
    chk("R11 empty", head_valid, 0);
    // R12 release after empty
    do_release();
    chk("R12 freed", busy, 0);
    chk("R12 no err", err, 0);

    // R5 forwarded issue
    do_alloc(32'h300, 2'd0, 0, 1, 8'd1);
    do_issue();
    chk("R5 release pulse", c_rel, 1);
    chk("R5 popped", prim_count, 0);
    chk("R5 not in service", in_service, 0);
    do_reset();
    do_alloc(32'h300, 2'd0, 0, 0, 8'd1);
    do_issue();
    chk("R5 normal pulse", c_rel, 0);
    chk("R5 normal in service", in_service, 1);

    // R6 early exclusive snoop rewrites primary upgrades
    do_reset();
    do_alloc(32'h400, 2'd2, 1, 0, 8'd1);
    do_add(2'd0, 0, 8'd2);
    do_snoop(1, 0, 8'd3);
    chk("R6 unhandled", c_h, 0);
    chk("R6 count unchanged", prim_count, 2);
    chk("R6 upgrade rewritten", head_cmd, 1);
    // R6 express with downstream pending rewrites deferred upgrade
    do_reset();
    do_alloc(32'h400, 2'd0, 0, 0, 8'd1);
    do_issue();
    do_add(2'd2, 1, 8'd2);
    chk("R3 upgrade deferred", def_count, 1);
    ds_pend = 1;
    do_snoop(1, 1, 8'd3);
    ds_pend = 0;
    chk("R6 express unhandled", c_h, 0);
    chk("R6 express no append", prim_count, 1);
    do_pop();
    do_promote();
    chk("R6 deferred rewritten", head_cmd, 1);
    chk("R10 order from head", entry_order, 2);

    // R7/R8 exhaustive snoop sweep
    for (int k = 0; k < 32; k++) begin
      logic pe, se, xp, dsp, iss, pre, rec, shr;
      pe = k[0]; se = k[1]; xp = k[2]; dsp = k[3]; iss = k[4];
      pre = !iss || (xp && dsp);
      rec = !pre && (pe || se);
      shr = !pre && !pe && !se;
      do_reset();
      do_alloc(32'h500, pe ? 2'd1 : 2'd0, pe, 0, 8'd10);
      if (iss) do_issue();
      ds_pend = dsp;
      do_snoop(se, xp, 8'd20);
      ds_pend = 0;
      chk("R7 sweep handled", c_h, !pre);
      chk("R7 sweep shared", c_s, shr);
      chk("R8 sweep inhibit", c_i, rec && pe);
      chk("R8 sweep supply", c_x, rec && pe);
      chk("R7 sweep prim_count", prim_count, rec ? 2 : 1);
      chk("R8 sweep pinv", pend_inv, rec && se);
      chk("R7 sweep pshared", pend_shared, shr);
      if (rec) begin
        do_pop();
        chk("R7 sweep mem target", {head_cmd, head_cpu, head_order}, {1'b0, se, 1'b0, 8'd20});
      end
    end

    // R9 splice on exclusive fill
    do_reset();
    do_alloc(32'h600, 2'd0, 0, 0, 8'd1);
    do_issue();
    do_add(2'd2, 1, 8'd2);
    do_fill(0);
    chk("R9 fso clear", c_fso, 0);
    chk("R9 spliced prim", prim_count, 2);
    chk("R9 spliced def", def_count, 0);
    do_pop();
    chk("R9 spliced head", {head_cmd, head_cpu, head_order}, {2'd2, 1'b1, 8'd2});
    // R9 pending shared forces shared response, no splice
    do_reset();
    do_alloc(32'h600, 2'd0, 0, 0, 8'd1);
    do_issue();
    do_snoop(0, 0, 8'd5);
    do_add(2'd1, 1, 8'd2);
    do_fill(0);
    chk("R9 pshared fso", c_fso, 1);
    chk("R9 pshared no splice", def_count, 1);
    // R9 shared response, no splice
    do_reset();
    do_alloc(32'h600, 2'd0, 0, 0, 8'd1);
    do_issue();
    do_add(2'd1, 1, 8'd2);
    do_fill(1);
    chk("R9 shared fso", c_fso, 1);
    chk("R9 shared no splice", def_count, 1);

    // R12 illegal release sets sticky error
    do_release();
    chk("R12 still busy", busy, 1);
    chk("R12 err set", err, 1);
    do_pop();
    do_promote();
    do_pop();
    do_release();
    chk("R12 freed after empty", busy, 0);
    chk("R12 err sticky", err, 1);
    do_reset();
    chk("R1 err cleared", err, 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule